// File: doc/BRIEF.md
# Serial Peripheral Master Port with Register Bank

This block is a memory-mapped synchronous serial port that drives an SPI bus as master. Software configures it through six word-spaced registers on a simple select/write-enable bus. It writes frames into an eight-entry transmit queue and collects the frames that come back from an eight-entry receive queue. A shift engine moves one frame at a time. Frames are 4 to 16 bits long, go out most significant bit first, and can use any combination of clock polarity and clock phase.

The engine does not divide the clock itself. A separate divider supplies a `tick_i` pulse for every half bit period. This block exports the prescale register and the 8-bit rate field of control register 0 so that the divider can set that pulse rate. Chip selects are driven elsewhere, by general-purpose outputs. An internal loopback path connects the serial output to the serial input for self-test. Three interrupt sources share one output: receive request, transmit request and receive overrun. Each source has its own enable.

Top module: `spi_master_regs`

## Requirements
- R1: After reset every control, prescale and interrupt register reads zero. Status reads 0x0003: transmit queue empty and not full. `irq_o` and `sclk_o` are low.
- R2: Control 0 is held as a full 16-bit word, control 1 in bits 6:0 and prescale in bits 7:0. Each reads back what was written. `prescale_o` mirrors the prescale register and `rate_o` mirrors control 0 bits 15:8.
- R3: The frame length is control 0 bits 3:0 plus one. Field values below 3 are treated as 3, which gives a 4-bit frame.
- R4: Bits leave MSB first. `sclk_o` rests at the polarity bit (control 0 bit 7) and toggles once per tick, 2N times for an N-bit frame. With the phase bit (control 0 bit 6) clear, data is valid on the first edge of each bit. With it set, data is valid on the second edge. A frame starts only on a tick.
- R5: Every frame sent yields one received frame. The frame is right-justified and its unused upper bits read as zero. With loopback (control 1 bit 3) set, `mosi_o` is the receive input and `miso_i` is ignored.
- R6: Each queue holds 8 entries. The status register is laid out as: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 4 busy. Busy means the engine is active or the transmit queue is not empty. A write to the data register (0x08) while the transmit queue is full is dropped. A read of the data register pops one receive entry, and reads 0 when the receive queue is empty.
- R7: A frame that completes while the receive queue is full is discarded and sets the overrun flag. The flag stays set until any write to address 0x14.
- R8: The transmit request is active while the transmit queue holds at most 4 entries. The receive request is active while the receive queue holds at least 4 entries. Reading 0x14 returns these requests and the overrun flag in bits 0 (receive), 1 (transmit) and 2 (overrun), each ANDed with its enable in control 1 bits 0, 1 and 2. `irq_o` is the OR of the three gated bits.
- R9: While the port enable (control 1 bit 4) is clear, no frame starts. Clearing it during a frame abandons that frame without a receive push, and `sclk_o` returns to its resting level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 5 | Byte address: 0x00 ctrl0, 0x04 ctrl1, 0x08 data, 0x0C status, 0x10 prescale, 0x14 interrupt |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| tick_i | input | 1 | Half-bit pulse from the external divider |
| prescale_o | output | 8 | Prescale value for the divider |
| rate_o | output | 8 | Rate field for the divider |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: queue depth 8, maximum frame width 16 and both request thresholds at 4. With depth 8, filling a queue, overflowing it, overrunning the receive side and crossing both request thresholds each take only a few frames. A 16-bit maximum width makes both the widest frame and the clamped 4-bit frame reachable. The bench also exercises every polarity and phase combination against a bit sniffer on the serial pins.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    RI_CR0  = 3'd0,
    RI_CR1  = 3'd1,
    RI_DATA = 3'd2,
    RI_STAT = 3'd3,
    RI_PSC  = 3'd4,
    RI_INT  = 3'd5
  } reg_idx_e;

  localparam int C0_CPHA  = 6;
  localparam int C0_CPOL  = 7;
  localparam int C1_RIE   = 0;
  localparam int C1_TIE   = 1;
  localparam int C1_RORIE = 2;
  localparam int C1_LBK   = 3;
  localparam int C1_EN    = 4;
  localparam int C1_W     = 7;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rp_q];
  assign level_o = lvl_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (level_o == $past(level_o)));
  a_r6_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int MAX_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       tick_i,
  input  logic                       cpol_i,
  input  logic                       cpha_i,
  input  logic [$clog2(MAX_W)-1:0]   size_m1_i,
  input  logic                       tx_valid_i,
  input  logic [MAX_W-1:0]           tx_data_i,
  output logic                       tx_pop_o,
  output logic                       rx_push_o,
  output logic [MAX_W-1:0]           rx_data_o,
  input  logic                       sin_i,
  output logic                       sout_o,
  output logic                       sclk_o,
  output logic                       busy_o
);
  localparam int SW = $clog2(MAX_W);
  localparam int CW = SW + 1;

  logic             act_q, phase_q, done_q;
  logic [CW-1:0]    edge_q;
  logic [SW-1:0]    size_q;
  logic [MAX_W-1:0] tsr_q, rsr_q, mask;
  logic             lead, last, smp, shf, load;

  assign lead = ~edge_q[0];
  assign last = (edge_q == {size_q, 1'b1});
  assign smp  = lead ^ cpha_i;
  assign shf  = cpha_i ? (lead && edge_q != '0) : (~lead && ~last);
  assign load = en_i & ~act_q & tick_i & tx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      edge_q  <= '0;
      size_q  <= '0;
      tsr_q   <= '0;
      rsr_q   <= '0;
    end else if (!en_i) begin
      act_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      edge_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        act_q   <= 1'b1;
        phase_q <= 1'b0;
        edge_q  <= '0;
        size_q  <= size_m1_i;
        tsr_q   <= tx_data_i;
        rsr_q   <= '0;
      end else if (act_q && tick_i) begin
        phase_q <= ~phase_q;
        edge_q  <= edge_q + CW'(1);
        if (smp) rsr_q <= {rsr_q[MAX_W-2:0], sin_i};
        if (shf) tsr_q <= {tsr_q[MAX_W-2:0], 1'b0};
        if (last) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_W; i++) mask[i] = (i <= int'(size_q));
  end

  assign tx_pop_o  = load;
  assign rx_push_o = done_q;
  assign rx_data_o = rsr_q & mask;
  assign sout_o    = tsr_q[size_q];
  assign sclk_o    = cpol_i ^ phase_q;
  assign busy_o    = act_q;

  a_r4_start_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tick_i));
  a_r4_idle_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o == cpol_i));
  a_r9_disable_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
  a_r5_push_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(busy_o));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_W      = 16,
  parameter int MIN_W      = 4,
  parameter int TX_REQ_LVL = 4,
  parameter int RX_REQ_LVL = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [4:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        tick_i,
  output logic [7:0]  prescale_o,
  output logic [7:0]  rate_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  localparam int LW = $clog2(FIFO_DEPTH+1);
  localparam int SW = $clog2(MAX_W);

  logic [15:0]      cr0_q;
  logic [C1_W-1:0]  cr1_q;
  logic [7:0]       psc_q;
  logic             ror_q;

  logic             hit, wr_en, rd_en;
  reg_idx_e         idx;
  logic [SW-1:0]    size_m1;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic [MAX_W-1:0] tx_head, rx_head, eng_rx;
  logic             eng_pop, eng_push, eng_busy, sout, sin;
  logic [2:0]       int_bits;

  assign idx   = reg_idx_e'(bus_addr_i[4:2]);
  assign hit   = bus_sel_i & (bus_addr_i[1:0] == 2'b00);
  assign wr_en = hit & bus_we_i;
  assign rd_en = hit & ~bus_we_i;

  assign size_m1 = (cr0_q[SW-1:0] < SW'(MIN_W-1)) ? SW'(MIN_W-1) : cr0_q[SW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr0_q <= '0;
      cr1_q <= '0;
      psc_q <= '0;
      ror_q <= 1'b0;
    end else begin
      if (wr_en && idx == RI_CR0) cr0_q <= bus_wdata_i;
      if (wr_en && idx == RI_CR1) cr1_q <= bus_wdata_i[C1_W-1:0];
      if (wr_en && idx == RI_PSC) psc_q <= bus_wdata_i[7:0];
      // set has priority over a same-cycle clear
      if (eng_push && rx_full)          ror_q <= 1'b1;
      else if (wr_en && idx == RI_INT)  ror_q <= 1'b0;
    end
  end

  spim_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (wr_en && idx == RI_DATA),
    .din_i  (bus_wdata_i[MAX_W-1:0]),
    .pop_i  (eng_pop),
    .dout_o (tx_head),
    .level_o(tx_lvl),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  spim_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (eng_push),
    .din_i  (eng_rx),
    .pop_i  (rd_en && idx == RI_DATA),
    .dout_o (rx_head),
    .level_o(rx_lvl),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  assign sin = cr1_q[C1_LBK] ? sout : miso_i;

  spim_shift #(.MAX_W(MAX_W)) u_eng (
    .clk_i, .rst_ni,
    .en_i      (cr1_q[C1_EN]),
    .tick_i,
    .cpol_i    (cr0_q[C0_CPOL]),
    .cpha_i    (cr0_q[C0_CPHA]),
    .size_m1_i (size_m1),
    .tx_valid_i(~tx_empty),
    .tx_data_i (tx_head),
    .tx_pop_o  (eng_pop),
    .rx_push_o (eng_push),
    .rx_data_o (eng_rx),
    .sin_i     (sin),
    .sout_o    (sout),
    .sclk_o    (sclk_o),
    .busy_o    (eng_busy)
  );

  assign int_bits[0] = cr1_q[C1_RIE]   & (rx_lvl >= LW'(RX_REQ_LVL));
  assign int_bits[1] = cr1_q[C1_TIE]   & (tx_lvl <= LW'(TX_REQ_LVL));
  assign int_bits[2] = cr1_q[C1_RORIE] & ror_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      unique case (idx)
        RI_CR0:  bus_rdata_o = cr0_q;
        RI_CR1:  bus_rdata_o = 16'(cr1_q);
        RI_DATA: bus_rdata_o = rx_empty ? '0 : 16'(rx_head);
        RI_STAT: bus_rdata_o = {11'b0, eng_busy | ~tx_empty, rx_full, ~rx_empty, ~tx_full, tx_empty};
        RI_PSC:  bus_rdata_o = {8'b0, psc_q};
        RI_INT:  bus_rdata_o = {13'b0, int_bits};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign prescale_o = psc_q;
  assign rate_o     = cr0_q[15:8];
  assign mosi_o     = sout;
  assign irq_o      = |int_bits;

  a_r7_ror_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ror_q && !(wr_en && idx == RI_INT)) |=> ror_q);
  a_r7_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && idx == RI_INT && !(eng_push && rx_full)) |=> !ror_q);
  a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cr1_q[C1_RORIE:C1_RIE] != 3'b000));
endmodule

// File: tb/sim_spi_master_regs.sv
module sim_spi_master_regs;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_CR0 = 5'h00, A_CR1 = 5'h04, A_DAT = 5'h08,
                         A_STA = 5'h0C, A_PSC = 5'h10, A_INT = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        tick = 1'b0, tick_en = 1'b0;
  logic [7:0]  psc_o, rate_o;
  logic        sclk, mosi, miso = 1'b0, irq;

  int n_chk = 0, n_err = 0;
  logic        m_cpol = 1'b0, m_cpha = 1'b0, sniff_on = 1'b0;
  logic [15:0] cap;
  int          ncap;
  int          exp_q[$];
  logic [15:0] rv;

  spi_master_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick), .prescale_o(psc_o),
    .rate_o(rate_o), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) tick <= tick_en & ~tick;

  // bit sniffer on the serial pins: captures data on the sampling edge of the mode
  always @(posedge sclk or negedge sclk) begin
    if (sniff_on && (((sclk != m_cpol)) ^ m_cpha)) begin
      cap  = {cap[14:0], mosi};
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STA, s);
      if (!s[4]) begin
        repeat (4) @(negedge clk);
        return;
      end
    end
    chk("R6 busy never cleared", 1, 0);
  endtask

  task automatic run_one(input logic [15:0] c0, input logic [15:0] d);
    int f, n;
    logic [15:0] msk;
    f = int'(c0[3:0]);
    n = ((f < 3) ? 3 : f) + 1;
    msk = 16'((32'h1 << n) - 1);
    wr(A_CR1, 16'h0000);
    wr(A_CR0, c0);
    wr(A_CR1, 16'h0018);
    m_cpol = c0[7]; m_cpha = c0[6];
    cap = '0; ncap = 0; sniff_on = 1'b1;
    wr(A_DAT, d);
    tick_en = 1'b1;
    wait_idle();
    tick_en = 1'b0;
    sniff_on = 1'b0;
    chk("R3 edge count equals frame length", ncap, n);
    chk("R4 MSB-first bits on sampling edges", int'(cap & msk), int'(d & msk));
    chk("R4 clock rests at polarity", int'(sclk), int'(c0[7]));
    rd(A_DAT, rv);
    chk("R5 loopback receive right-justified", int'(rv), int'(d & msk));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STA, rv); chk("R1 status after reset", int'(rv), 16'h0003);
    rd(A_CR0, rv); chk("R1 ctrl0 after reset", int'(rv), 0);
    rd(A_CR1, rv); chk("R1 ctrl1 after reset", int'(rv), 0);
    rd(A_INT, rv); chk("R1 int after reset", int'(rv), 0);
    chk("R1 irq low", int'(irq), 0);
    chk("R1 sclk low", int'(sclk), 0);

    // R2 register readback and divider outputs
    wr(A_CR0, 16'hA5C7);
    rd(A_CR0, rv); chk("R2 ctrl0 readback", int'(rv), 16'hA5C7);
    wr(A_PSC, 16'hFF3C);
    rd(A_PSC, rv); chk("R2 prescale readback", int'(rv), 16'h003C);
    chk("R2 prescale_o", int'(psc_o), 16'h3C);
    chk("R2 rate_o", int'(rate_o), 16'hA5);
    wr(A_CR1, 16'hFFE0);
    rd(A_CR1, rv); chk("R2 ctrl1 readback", int'(rv), 16'h0060);

    // R3 R4 R5 all four modes, several sizes
    run_one(16'h0007, 16'h00B6);
    run_one(16'h0047, 16'h0059);
    run_one(16'h0087, 16'h00C3);
    run_one(16'h00CB, 16'h0A5E);
    run_one(16'h000F, 16'hBEEF);
    run_one(16'h00C1, 16'hFFFB);   // R3 clamp to 4 bits
    run_one(16'h0000, 16'h0009);   // R3 clamp to 4 bits

    // R5 external input, zero extension, loopback off
    wr(A_CR1, 16'h0000);
    wr(A_CR0, 16'h0004);
    miso = 1'b1;
    wr(A_CR1, 16'h0010);
    wr(A_DAT, 16'h0000);
    tick_en = 1'b1; wait_idle(); tick_en = 1'b0;
    rd(A_DAT, rv); chk("R5 external input zero-extended", int'(rv), 16'h001F);
    miso = 1'b0;

    // R6 R9 fill transmit queue while disabled, ticks running
    wr(A_CR1, 16'h0000);
    wr(A_CR0, 16'h000F);
    tick_en = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wr(A_DAT, 16'(16'h1100 + i * 16'h0101));
      if (i < 8) exp_q.push_back(16'h1100 + i * 16'h0101);
    end
    repeat (20) @(negedge clk);
    rd(A_STA, rv); chk("R9 no frame while disabled / R6 tx full", int'(rv), 16'h0010);
    wr(A_CR1, 16'h0002);
    rd(A_INT, rv); chk("R8 tx request off at level 8", int'(rv), 0);

    // run 8 frames into receive queue
    wr(A_CR1, 16'h001D);
    wait_idle();
    tick_en = 1'b0;
    rd(A_STA, rv); chk("R6 rx full status", int'(rv), 16'h000F);
    rd(A_INT, rv); chk("R8 rx request at level 8", int'(rv), 16'h0001);
    chk("R8 irq from rx request", int'(irq), 1);
    for (int i = 0; i < 4; i++) begin
      rd(A_DAT, rv); chk("R6 rx data order", int'(rv), exp_q.pop_front());
    end
    rd(A_INT, rv); chk("R8 rx request at level 4", int'(rv), 16'h0001);
    rd(A_DAT, rv); chk("R6 rx data order", int'(rv), exp_q.pop_front());
    rd(A_INT, rv); chk("R8 rx request off at level 3", int'(rv), 0);
    chk("R8 irq low", int'(irq), 0);
    for (int i = 0; i < 3; i++) begin
      rd(A_DAT, rv); chk("R6 rx data order", int'(rv), exp_q.pop_front());
    end
    rd(A_DAT, rv); chk("R6 empty read gives zero", int'(rv), 0);

    // R7 overrun
    tick_en = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wr(A_DAT, 16'(16'h2200 + i));
      if (i < 8) exp_q.push_back(16'h2200 + i);
    end
    wait_idle();
    tick_en = 1'b0;
    rd(A_INT, rv); chk("R7 overrun flagged", int'(rv), 16'h0005);
    rd(A_INT, rv); chk("R7 overrun stays set", int'(rv), 16'h0005);
    wr(A_INT, 16'h0000);
    rd(A_INT, rv); chk("R7 overrun cleared by write", int'(rv), 16'h0001);
    for (int i = 0; i < 8; i++) begin
      rd(A_DAT, rv); chk("R7 overrunning frame discarded", int'(rv), exp_q.pop_front());
    end
    rd(A_STA, rv); chk("R6 all drained", int'(rv), 16'h0003);

    // R8 transmit request threshold
    wr(A_CR1, 16'h0012);
    rd(A_INT, rv); chk("R8 tx request when empty", int'(rv), 16'h0002);
    for (int i = 0; i < 4; i++) begin
      wr(A_DAT, 16'(16'h3300 + i)); exp_q.push_back(16'h3300 + i);
    end
    rd(A_INT, rv); chk("R8 tx request at level 4", int'(rv), 16'h0002);
    chk("R8 irq from tx request", int'(irq), 1);
    wr(A_DAT, 16'h3304); exp_q.push_back(16'h3304);
    rd(A_INT, rv); chk("R8 tx request off at level 5", int'(rv), 0);
    wr(A_CR1, 16'h0018);
    tick_en = 1'b1; wait_idle(); tick_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      rd(A_DAT, rv); chk("R5 one frame in per frame out", int'(rv), exp_q.pop_front());
    end
    rd(A_STA, rv); chk("R5 no extra frames", int'(rv), 16'h0003);

    // R9 disable mid-frame
    wr(A_CR0, 16'h008F);
    wr(A_DAT, 16'h5A5A);
    tick_en = 1'b1;
    repeat (14) @(negedge clk);
    wr(A_CR1, 16'h0008);
    repeat (60) @(negedge clk);
    tick_en = 1'b0;
    rd(A_STA, rv); chk("R9 abandoned frame pushes nothing", int'(rv), 16'h0003);
    chk("R9 sclk back at rest", int'(sclk), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule